// File: doc/BRIEF.md
# UART Interrupt Pending and Mask Unit

This block collects the four interrupt causes of a UART channel (received data, receive error, transmitted data and modem status change) and turns them into one interrupt request line. Each cause arrives as a one-cycle event pulse. It first lands in a raw source-pending register, whatever the mask. A mask register then decides which raw bits may move on into a second, masked pending register. The interrupt line is high while any masked pending bit is set. Software clears either pending layer by writing ones to the bits it wants cleared.

Alongside the interrupt logic, the block keeps a sticky error status register. Whenever the receive-error event fires, the error condition flags present in that cycle are ORed into this register. A read of the register returns the gathered flags and clears them. Because masking acts only between the two pending layers, software can mask the error source while it services a fault and unmask it afterwards without losing an event that arrived in between.

The register port is plain control: a write strobe, a read strobe, a two-bit register select and four data bits. Read data is a combinational function of the select. The port has no handshake and no back-pressure, and every access completes in the cycle it is presented.

Top module: `uart_irq_ctrl`

## Requirements
- R1: After reset, raw pending = 0, masked pending = 0, mask = 4'b1111 (all sources disabled), error status = 0 and irq = 0.
- R2: An event pulse sets its raw pending bit on the next clock edge, whatever the mask. Bit map used by all three interrupt registers: bit 0 received data, bit 1 receive error, bit 2 transmitted data, bit 3 modem.
- R3: A masked pending bit sets on the edge after its raw pending bit is seen set while its mask bit is 0. It never sets while its mask bit is 1.
- R4: Writing to select 0 (raw pending) clears each bit whose data bit is 1 and leaves bits written with 0 unchanged.
- R5: Writing to select 1 (masked pending) clears each bit written with 1, provided the raw bit is no longer pending and unmasked.
- R6: When a set condition and a write-1-to-clear hit the same bit in the same cycle, in either pending register, the bit ends up set.
- R7: irq is high exactly while at least one masked pending bit is set.
- R8: On a receive-error event, the error flags are ORed into the error status (bit 0 overrun, bit 1 parity, bit 2 framing, bit 3 break). Bits stay set until the register is read, and several can be set together.
- R9: Reading select 3 returns the error status and clears it on that clock edge. Flags captured in the same cycle as the read survive into the next value.
- R10: Masking a source keeps its raw pending bit. Unmasking it later raises the masked pending bit and irq.
- R11: Writing to select 2 loads the mask, and reading select 2 returns it. A mask bit of 1 disables its source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_data_ev | input | 1 | Received-data event pulse |
| rx_err_ev | input | 1 | Receive-error event pulse |
| tx_data_ev | input | 1 | Transmit-data event pulse |
| modem_ev | input | 1 | Modem status event pulse |
| err_flags | input | 4 | Error conditions, sampled with rx_err_ev |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears error status at select 3) |
| reg_addr | input | 2 | Register select: 0 raw pending, 1 masked pending, 2 mask, 3 error status |
| reg_wdata | input | 4 | Write data |
| reg_rdata | output | 4 | Read data of the selected register |
| irq | output | 1 | Interrupt request |

## Verification
The hardest cases to reach are same-cycle collisions. One is a new event meeting a write-1-to-clear on the same raw bit. Another is a clear of a masked pending bit whose raw source is still live and unmasked. A third is an error flag arriving in the very cycle the status register is read. The stimulus reaches each of them from the ports by driving the event pulse and the register access in the same clock cycle. For the masking case, it first builds up a raw pending bit under mask and then opens the mask, so that late delivery of the held event is seen at the interrupt line.

// File: rtl/uip_pkg.sv
package uip_pkg;
  localparam int SRC_W = 4;
  localparam int ERR_W = 4;
  localparam int REG_W = 4;
  localparam int SEL_W = 2;

  localparam int BIT_RXD   = 0;
  localparam int BIT_ERR   = 1;
  localparam int BIT_TXD   = 2;
  localparam int BIT_MODEM = 3;

  localparam logic [SRC_W-1:0] MASK_RESET = '1;

  typedef enum logic [SEL_W-1:0] {
    SEL_RAW  = 2'd0,
    SEL_PEND = 2'd1,
    SEL_MASK = 2'd2,
    SEL_ERR  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/uip_sticky_bank.sv
// Bank of sticky bits: set wins over a write-1 clear in the same cycle.
module uip_sticky_bank #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          q_o[i] <= 1'b0;
      else if (set_i[i])   q_o[i] <= 1'b1;
      else if (clr_i[i])   q_o[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/uip_mask_reg.sv
module uip_mask_reg #(
  parameter int          W        = 4,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] data_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q_o <= RST_VAL;
    else if (load_i) q_o <= data_i;
  end
endmodule

// File: rtl/uip_err_stat.sv
// Sticky error flags, cleared by a read; a capture in the read cycle survives.
module uip_err_stat #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         capture_i,
  input  logic [W-1:0] flags_i,
  input  logic         rd_clr_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] fresh;
  logic [W-1:0] kept;

  assign fresh = capture_i ? flags_i : '0;
  assign kept  = rd_clr_i ? '0 : q_o;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_o <= '0;
    else        q_o <= kept | fresh;
  end
endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uip_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_data_ev,
  input  logic             rx_err_ev,
  input  logic             tx_data_ev,
  input  logic             modem_ev,
  input  logic [ERR_W-1:0] err_flags,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [SEL_W-1:0] reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq
);
  logic [SRC_W-1:0] ev_vec;
  logic [SRC_W-1:0] src_q;
  logic [SRC_W-1:0] pend_q;
  logic [SRC_W-1:0] mask_q;
  logic [ERR_W-1:0] err_q;
  logic [SRC_W-1:0] raw_clr;
  logic [SRC_W-1:0] pend_clr;
  logic [SRC_W-1:0] pend_set;
  logic             mask_load;
  logic             err_rd;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    ev_vec            = '0;
    ev_vec[BIT_RXD]   = rx_data_ev;
    ev_vec[BIT_ERR]   = rx_err_ev;
    ev_vec[BIT_TXD]   = tx_data_ev;
    ev_vec[BIT_MODEM] = modem_ev;
  end

  assign raw_clr   = (reg_wr && sel == SEL_RAW)  ? reg_wdata[SRC_W-1:0] : '0;
  assign pend_clr  = (reg_wr && sel == SEL_PEND) ? reg_wdata[SRC_W-1:0] : '0;
  assign mask_load = reg_wr && sel == SEL_MASK;
  assign err_rd    = reg_rd && sel == SEL_ERR;
  assign pend_set  = src_q & ~mask_q;

  uip_sticky_bank #(.W(SRC_W)) u_raw (
    .clk(clk), .rst_n(rst_n), .set_i(ev_vec), .clr_i(raw_clr), .q_o(src_q)
  );

  uip_mask_reg #(.W(SRC_W), .RST_VAL(MASK_RESET)) u_mask (
    .clk(clk), .rst_n(rst_n), .load_i(mask_load),
    .data_i(reg_wdata[SRC_W-1:0]), .q_o(mask_q)
  );

  uip_sticky_bank #(.W(SRC_W)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(pend_set), .clr_i(pend_clr), .q_o(pend_q)
  );

  uip_err_stat #(.W(ERR_W)) u_err (
    .clk(clk), .rst_n(rst_n), .capture_i(rx_err_ev), .flags_i(err_flags),
    .rd_clr_i(err_rd), .q_o(err_q)
  );

  always_comb begin
    unique case (sel)
      SEL_RAW:  reg_rdata = REG_W'(src_q);
      SEL_PEND: reg_rdata = REG_W'(pend_q);
      SEL_MASK: reg_rdata = REG_W'(mask_q);
      SEL_ERR:  reg_rdata = REG_W'(err_q);
      default:  reg_rdata = '0;
    endcase
  end

  assign irq = |pend_q;
endmodule

// File: rtl/uip_checker.sv
module uip_checker
  import uip_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [SRC_W-1:0] ev,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [SEL_W-1:0] reg_addr,
  input logic [REG_W-1:0] reg_wdata,
  input logic [ERR_W-1:0] err_flags,
  input logic [SRC_W-1:0] src_q,
  input logic [SRC_W-1:0] pend_q,
  input logic [SRC_W-1:0] mask_q,
  input logic [ERR_W-1:0] err_q,
  input logic             irq
);
  logic err_read;
  assign err_read = reg_rd && reg_addr == SEL_ERR;

  for (genvar i = 0; i < SRC_W; i++) begin : g_src
    AST_EVENT_SETS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
      ev[i] |=> src_q[i]) else $error("raw bit not set"); // R2
    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (ev[i] && reg_wr && reg_addr == SEL_RAW && reg_wdata[i]) |=> src_q[i])
      else $error("clear beat set"); // R6
    AST_UNMASKED_PENDS: assert property (@(posedge clk) disable iff (!rst_n)
      (src_q[i] && !mask_q[i]) |=> pend_q[i]) else $error("pend missed"); // R3
    AST_NO_MASKED_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[i]) |-> $past(src_q[i] && !mask_q[i])) else $error("spurious pend"); // R3
  end

  AST_IRQ_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(|(src_q & ~mask_q))) else $error("irq without cause"); // R7
  AST_ERR_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (err_read && !ev[BIT_ERR]) |=> err_q == '0) else $error("error status kept"); // R9
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_read) |=> ((err_q & $past(err_q)) == $past(err_q))) else $error("error bit lost"); // R8
  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == SEL_MASK) |=> $stable(mask_q)) else $error("mask changed"); // R11
endmodule

bind uart_irq_ctrl uip_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ev(ev_vec), .reg_wr(reg_wr), .reg_rd(reg_rd),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .err_flags(err_flags),
  .src_q(src_q), .pend_q(pend_q), .mask_q(mask_q), .err_q(err_q), .irq(irq)
);

// File: tb/tb_uart_irq_ctrl.sv
module tb_uart_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_data_ev = 1'b0, rx_err_ev = 1'b0, tx_data_ev = 1'b0, modem_ev = 1'b0;
  logic [3:0] err_flags = '0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [3:0] reg_wdata = '0;
  logic [3:0] reg_rdata;
  logic       irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  typedef struct {
    bit         is_irq;
    logic [3:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #10 clk = ~clk;

  uart_irq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .rx_data_ev(rx_data_ev), .rx_err_ev(rx_err_ev),
    .tx_data_ev(tx_data_ev), .modem_ev(modem_ev), .err_flags(err_flags),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // Monitor: compares results against queued expectations.
  always @(negedge clk) begin
    #5;
    if (sb.size() > 0) begin
      item_t it;
      logic [3:0] act;
      it  = sb.pop_front();
      act = it.is_irq ? {3'b000, irq} : reg_rdata;
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s: actual=%b expected=%b", it.tag, act, it.exp);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected<20000 cycles", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // ev bit map: 0 rxd, 1 err, 2 txd, 3 modem
  task automatic drive(input logic [3:0] ev, input logic [3:0] ef, input logic wr,
                       input logic rd, input logic [1:0] a, input logic [3:0] wd);
    @(negedge clk);
    rx_data_ev = ev[0]; rx_err_ev = ev[1]; tx_data_ev = ev[2]; modem_ev = ev[3];
    err_flags = ef; reg_wr = wr; reg_rd = rd; reg_addr = a; reg_wdata = wd;
  endtask

  task automatic idle();
    drive(4'b0, 4'b0, 1'b0, 1'b0, 2'd0, 4'b0);
  endtask

  task automatic read_exp(input logic [1:0] a, input logic [3:0] exp, input string tag);
    item_t it;
    idle();
    drive(4'b0, 4'b0, 1'b0, 1'b1, a, 4'b0);
    it.is_irq = 1'b0; it.exp = exp; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic irq_exp(input logic exp, input string tag);
    item_t it;
    idle();
    it.is_irq = 1'b1; it.exp = {3'b000, exp}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    read_exp(2'd0, 4'b0000, "R1 raw");
    read_exp(2'd1, 4'b0000, "R1 pend");
    read_exp(2'd2, 4'b1111, "R1 mask");
    read_exp(2'd3, 4'b0000, "R1 err");
    irq_exp(1'b0, "R1 irq");
    // R2 events set raw bits under full mask; R3 no pend while masked
    drive(4'b0001, 4'b0, 1'b0, 1'b0, 2'd0, 4'b0);
    read_exp(2'd0, 4'b0001, "R2 rxd raw");
    read_exp(2'd1, 4'b0000, "R3 masked no pend");
    drive(4'b1100, 4'b0, 1'b0, 1'b0, 2'd0, 4'b0);
    read_exp(2'd0, 4'b1101, "R2 txd+modem raw");
    // R11 mask write; R3 pend after unmask; R7 irq
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd2, 4'b1110);
    read_exp(2'd2, 4'b1110, "R11 mask readback");
    read_exp(2'd1, 4'b0001, "R3 pend set");
    irq_exp(1'b1, "R7 irq high");
    // R4 raw clear, R5 pend clear
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd0, 4'b0001);
    idle();
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd1, 4'b0001);
    read_exp(2'd1, 4'b0000, "R5 pend cleared");
    read_exp(2'd0, 4'b1100, "R4 raw partial clear");
    irq_exp(1'b0, "R7 irq low");
    // R6 set beats clear on raw
    drive(4'b0010, 4'b0, 1'b1, 1'b0, 2'd0, 4'b0010);
    read_exp(2'd0, 4'b1110, "R6 raw set wins");
    read_exp(2'd1, 4'b0000, "R10 masked err held back");
    // R10 unmask later
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd2, 4'b1100);
    read_exp(2'd1, 4'b0010, "R10 pend after unmask");
    irq_exp(1'b1, "R10 irq");
    // R6 pend clear loses while source live
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd1, 4'b0010);
    read_exp(2'd1, 4'b0010, "R6 pend set wins");
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd0, 4'b0010);
    idle();
    drive(4'b0, 4'b0, 1'b1, 1'b0, 2'd1, 4'b0010);
    read_exp(2'd1, 4'b0000, "R5 pend cleared after source");
    // R8 sticky combined error flags
    drive(4'b0010, 4'b0001, 1'b0, 1'b0, 2'd0, 4'b0);
    drive(4'b0010, 4'b0110, 1'b0, 1'b0, 2'd0, 4'b0);
    read_exp(2'd3, 4'b0111, "R8 combined errors");
    read_exp(2'd3, 4'b0000, "R9 cleared by read");
    // R9 capture in the read cycle survives
    begin
      item_t it;
      idle();
      drive(4'b0010, 4'b1000, 1'b0, 1'b1, 2'd3, 4'b0);
      it.is_irq = 1'b0; it.exp = 4'b0000; it.tag = "R9 read during capture";
      sb.push_back(it);
    end
    read_exp(2'd3, 4'b1000, "R9 break survives");
    read_exp(2'd3, 4'b0000, "R9 cleared again");
    idle();
    idle();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule